// File: doc/BRIEF.md
# Serial Port Interrupt Prioritizer

This block holds the interrupt enable register of a serial port and turns five raw event conditions into one prioritized identification byte and a single interrupt line. The receiver and modem side hand in their conditions as plain levels: line status error, received data available, character timeout and modem status change. The transmit side hands in a buffer-empty level and the buffer occupancy. From these the block keeps its own pending latch for the transmit-empty event.

The identification byte is registered, so it reflects the conditions one clock after they are presented. While the processor is reading it, the byte is held stable. Conditions that arrive during the read are still captured and appear after the read ends. The transmit-empty latch clears on a write into the transmit buffer. It also clears on a read of the identification byte when that byte shows transmit-empty. In FIFO mode the block can hold back the empty indication by a programmable number of clocks, which stands for one character time less the final stop bit.

Top module: `uart_irq_ident`

## Requirements
- R1: The low nibble of the identification byte selects the highest-priority enabled source. The codes, from highest to lowest priority, are: line error 4'b0110, data available 4'b0100, timeout 4'b1100 (same level as data available but below it, and reported only in FIFO mode), transmit empty 4'b0010, modem 4'b0000. With no source enabled and active the nibble is 4'b0001. The byte updates one clock after its inputs change.
- R2: Bit 0 of the byte is 0 exactly when an interrupt is pending. Bits 5:4 are always 0. Bits 7:6 are 2'b11 in FIFO mode and 2'b00 otherwise. Bit 3 is 0 outside FIFO mode.
- R3: While the identification read strobe is high the byte does not change. A condition raised during the read shows one clock after the strobe falls.
- R4: Enable bit 0 gates data available and timeout, bit 1 gates transmit empty, bit 2 gates line error and bit 3 gates modem. The readback shows bits 3:0 as written and bits 7:4 as 0.
- R5: A disabled source is absent from the byte and does not raise the interrupt output. The interrupt output is high whenever the byte shows a pending interrupt.
- R6: The rising edge of the read strobe clears the transmit-empty latch when the byte shows 4'b0010. When a higher source is shown instead, the latch is kept.
- R7: A transmit-buffer write strobe clears the transmit-empty latch.
- R8: In FIFO mode, the empty indication is deferred by the programmed delay count when the occupancy has not reached 2 since the previous indication. Non-deferred, the interrupt is visible 2 clocks after the empty level rises; deferred, it is visible after delay+2 clocks.
- R9: After the FIFO-mode flag toggles while the buffer is empty, the transmit-empty interrupt appears without deferral, 3 clocks after the toggle.
- R10: The latch also sets when enable bit 1 goes from 0 to 1 while the empty indication is already active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| ierWrEn | input | 1 | Enable register write strobe |
| ierWrData | input | 8 | Enable register write data |
| iirRdEn | input | 1 | Identification read strobe (high for the whole access) |
| thrWrEn | input | 1 | Transmit buffer write strobe |
| fifoMode | input | 1 | FIFO mode flag |
| condLineErr | input | 1 | Line status error level |
| condRxAvail | input | 1 | Received data available level |
| condTimeout | input | 1 | Character timeout level |
| condModem | input | 1 | Modem status change level |
| condTxEmpty | input | 1 | Transmit buffer and shifter empty level |
| txLevel | input | 5 | Transmit buffer occupancy |
| txDelay | input | 8 | Deferral length in clocks |
| ierQ | output | 8 | Enable register readback |
| iirCode | output | 8 | Identification byte |
| intr | output | 1 | Interrupt line |

## Verification
Two functions can meet in one clock: the identification read that clears transmit-empty and the arrival of new conditions or a buffer write. The bench provokes this by raising a line error while a read is held open, and by pulsing a read while a higher source is shown over a pending transmit-empty. It judges the outcome from the frozen byte during the access and from the byte shown after it, which reveals whether the latch survived. A sweep over every enable mask, every combination of the four level conditions and both modes compares each byte against an arithmetic priority model.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef struct packed {
    logic freeze;
    logic setPend;
    logic clrPend;
  } irqStrobe_t;

  localparam logic [3:0] CODE_NONE  = 4'b0001;
  localparam logic [3:0] CODE_LINE  = 4'b0110;
  localparam logic [3:0] CODE_RXAV  = 4'b0100;
  localparam logic [3:0] CODE_TOUT  = 4'b1100;
  localparam logic [3:0] CODE_TXEM  = 4'b0010;
  localparam logic [3:0] CODE_MODEM = 4'b0000;
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             iirRdEn,
  input  logic             thrWrEn,
  input  logic             ierWrEn,
  input  logic             ierWrBit1,
  input  logic             ierBit1,
  input  logic             fifoMode,
  input  logic             condTxEmpty,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [DLY_W-1:0] txDelay,
  input  logic [3:0]       shownCode,
  output irqStrobe_t       strobe
);
  localparam logic [LVL_W-1:0] MULTI_LVL = LVL_W'(2);

  logic             fifoQ;
  logic             rdQ;
  logic             emptyInd;
  logic             emptyNext;
  logic [DLY_W-1:0] dlyCnt;
  logic [DLY_W-1:0] cntNext;
  logic             multiSeen;
  logic             firstAfter;
  logic             toggle;
  logic             deferNeed;
  logic             indRise;
  logic             rdStart;

  assign toggle    = fifoMode ^ fifoQ;
  assign deferNeed = fifoMode & ~multiSeen & ~firstAfter;
  assign rdStart   = iirRdEn & ~rdQ;

  always_comb begin
    emptyNext = 1'b0;
    cntNext   = '0;
    if (toggle || !condTxEmpty) begin
      emptyNext = 1'b0;
    end else if (emptyInd || !deferNeed) begin
      emptyNext = 1'b1;
    end else if (dlyCnt == txDelay) begin
      emptyNext = 1'b1;
    end else begin
      cntNext = dlyCnt + 1'b1;
    end
  end

  assign indRise = emptyNext & ~emptyInd;

  always_comb begin
    strobe.freeze  = iirRdEn;
    strobe.setPend = indRise | (ierWrEn & ierWrBit1 & ~ierBit1 & emptyInd);
    strobe.clrPend = thrWrEn | (rdStart & (shownCode == CODE_TXEM));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoQ      <= 1'b0;
      rdQ        <= 1'b0;
      emptyInd   <= 1'b0;
      dlyCnt     <= '0;
      multiSeen  <= 1'b0;
      firstAfter <= 1'b0;
    end else begin
      fifoQ    <= fifoMode;
      rdQ      <= iirRdEn;
      emptyInd <= emptyNext;
      dlyCnt   <= cntNext;
      if (toggle) begin
        firstAfter <= 1'b1;
        multiSeen  <= 1'b0;
      end else if (indRise) begin
        firstAfter <= 1'b0;
        multiSeen  <= 1'b0;
      end else if (fifoMode && txLevel >= MULTI_LVL) begin
        multiSeen <= 1'b1;
      end
    end
  end

  // R8: an empty indication only ever follows an empty buffer level
  assert_ind_needs_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(emptyInd) |-> $past(condTxEmpty));

  // R6: a read that starts on a transmit-empty code must request a clear
  assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (iirRdEn && !rdQ && shownCode == CODE_TXEM) |-> strobe.clrPend);
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  irqStrobe_t strobe,
  input  logic       ierWrEn,
  input  logic [7:0] ierWrData,
  input  logic       fifoMode,
  input  logic       condLineErr,
  input  logic       condRxAvail,
  input  logic       condTimeout,
  input  logic       condModem,
  output logic [3:0] ierBits,
  output logic [7:0] codeQ
);
  logic       txPend;
  logic [3:0] liveCode;
  logic [7:0] liveByte;

  always_comb begin
    if (condLineErr && ierBits[2])                  liveCode = CODE_LINE;
    else if (condRxAvail && ierBits[0])             liveCode = CODE_RXAV;
    else if (condTimeout && ierBits[0] && fifoMode) liveCode = CODE_TOUT;
    else if (txPend && ierBits[1])                  liveCode = CODE_TXEM;
    else if (condModem && ierBits[3])               liveCode = CODE_MODEM;
    else                                            liveCode = CODE_NONE;
    liveByte = {fifoMode, fifoMode, 2'b00, liveCode};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ierBits <= '0;
      txPend  <= 1'b0;
      codeQ   <= {4'b0000, CODE_NONE};
    end else begin
      if (ierWrEn) ierBits <= ierWrData[3:0];
      if (strobe.clrPend)      txPend <= 1'b0;
      else if (strobe.setPend) txPend <= 1'b1;
      if (!strobe.freeze) codeQ <= liveByte;
    end
  end

  // R3: the shown byte holds during a read access
  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.freeze |=> $stable(codeQ));

  // R4: transmit-empty never shown while its enable is off
  assert_gate_txem_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ierBits[1] && !strobe.freeze) |=> codeQ[3:0] != CODE_TXEM);

  // R7: a clear request empties the pending latch
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrPend |=> !txPend);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ierWrEn,
  input  logic [7:0]       ierWrData,
  input  logic             iirRdEn,
  input  logic             thrWrEn,
  input  logic             fifoMode,
  input  logic             condLineErr,
  input  logic             condRxAvail,
  input  logic             condTimeout,
  input  logic             condModem,
  input  logic             condTxEmpty,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [DLY_W-1:0] txDelay,
  output logic [7:0]       ierQ,
  output logic [7:0]       iirCode,
  output logic             intr
);
  irqStrobe_t strobe;
  logic [3:0] ierBits;
  logic [7:0] codeQ;

  uart_irq_ctrl #(.LVL_W(LVL_W), .DLY_W(DLY_W)) ctrl (
    .clk(clk), .rstN(rstN), .iirRdEn(iirRdEn), .thrWrEn(thrWrEn),
    .ierWrEn(ierWrEn), .ierWrBit1(ierWrData[1]), .ierBit1(ierBits[1]),
    .fifoMode(fifoMode), .condTxEmpty(condTxEmpty), .txLevel(txLevel),
    .txDelay(txDelay), .shownCode(codeQ[3:0]), .strobe(strobe)
  );

  uart_irq_dp dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ierWrEn(ierWrEn),
    .ierWrData(ierWrData), .fifoMode(fifoMode), .condLineErr(condLineErr),
    .condRxAvail(condRxAvail), .condTimeout(condTimeout),
    .condModem(condModem), .ierBits(ierBits), .codeQ(codeQ)
  );

  assign ierQ    = {4'b0000, ierBits};
  assign iirCode = codeQ;
  assign intr    = ~codeQ[0];

  // R2: outside FIFO mode the timeout bit stays low
  assert_bit3_R2: assert property (@(posedge clk) disable iff (!rstN)
    !iirCode[7] |-> !iirCode[3]);
endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ierWrEn = 1'b0;
  logic [7:0] ierWrData = '0;
  logic       iirRdEn = 1'b0;
  logic       thrWrEn = 1'b0;
  logic       fifoMode = 1'b0;
  logic       condLineErr = 1'b0;
  logic       condRxAvail = 1'b0;
  logic       condTimeout = 1'b0;
  logic       condModem = 1'b0;
  logic       condTxEmpty = 1'b0;
  logic [4:0] txLevel = '0;
  logic [7:0] txDelay = 8'd5;
  logic [7:0] ierQ;
  logic [7:0] iirCode;
  logic       intr;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident uut (
    .clk(clk), .rstN(rstN), .ierWrEn(ierWrEn), .ierWrData(ierWrData),
    .iirRdEn(iirRdEn), .thrWrEn(thrWrEn), .fifoMode(fifoMode),
    .condLineErr(condLineErr), .condRxAvail(condRxAvail),
    .condTimeout(condTimeout), .condModem(condModem),
    .condTxEmpty(condTxEmpty), .txLevel(txLevel), .txDelay(txDelay),
    .ierQ(ierQ), .iirCode(iirCode), .intr(intr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [3:0] en, input logic [3:0] c,
                                       input logic pend, input logic fm);
    logic [3:0] lo;
    if (c[0] && en[2])            lo = 4'b0110;
    else if (c[1] && en[0])       lo = 4'b0100;
    else if (c[2] && en[0] && fm) lo = 4'b1100;
    else if (pend && en[1])       lo = 4'b0010;
    else if (c[3] && en[3])       lo = 4'b0000;
    else                          lo = 4'b0001;
    return {fm, fm, 2'b00, lo};
  endfunction

  task automatic wrIer(input logic [7:0] v);
    ierWrEn = 1'b1; ierWrData = v;
    @(negedge clk);
    ierWrEn = 1'b0;
  endtask

  task automatic thrPulse();
    thrWrEn = 1'b1;
    @(negedge clk);
    thrWrEn = 1'b0;
  endtask

  task automatic rdPulse();
    iirRdEn = 1'b1;
    @(negedge clk);
    iirRdEn = 1'b0;
  endtask

  task automatic latency(output int n);
    n = 0;
    while (!intr && n < 60) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 reset code", iirCode, 8'h01);
    chk("R5 reset intr", intr, 0);
    chk("R4 reset enables", ierQ, 8'h00);

    wrIer(8'hFF);
    chk("R4 upper enable bits read 0", ierQ, 8'h0F);

    // R1 R2 R4 R5 sweep: all masks, level conditions, both modes
    for (int fm = 0; fm < 2; fm++) begin
      for (int en = 0; en < 16; en++) begin
        for (int c = 0; c < 16; c++) begin
          fifoMode = fm[0];
          ierWrEn = 1'b1; ierWrData = {4'hA, en[3:0]};
          {condModem, condTimeout, condRxAvail, condLineErr} = c[3:0];
          @(negedge clk);
          ierWrEn = 1'b0;
          @(negedge clk);
          chk("R1 R2 R4 sweep code", iirCode, model(en[3:0], c[3:0], 1'b0, fm[0]));
          chk("R5 sweep intr", intr, !model(en[3:0], c[3:0], 1'b0, fm[0])[0]);
        end
      end
    end
    {condModem, condTimeout, condRxAvail, condLineErr} = 4'b0000;
    fifoMode = 1'b0;
    wrIer(8'h02);
    repeat (2) @(negedge clk);

    // R8 non-FIFO: immediate
    condTxEmpty = 1'b1;
    latency(n);
    chk("R8 immediate latency", n, 2);
    chk("R1 txem code", iirCode, 8'h02);

    // R7 write clears
    condTxEmpty = 1'b0;
    thrPulse();
    @(negedge clk);
    chk("R7 write clears", iirCode, 8'h01);

    // R6 read clears when shown
    condTxEmpty = 1'b1;
    latency(n);
    rdPulse();
    chk("R3 R6 held during read", iirCode, 8'h02);
    @(negedge clk);
    chk("R6 read clears", iirCode, 8'h01);

    // R6 read keeps latch when a higher source is shown
    thrPulse();
    condTxEmpty = 1'b0;
    @(negedge clk);
    condTxEmpty = 1'b1;
    latency(n);
    wrIer(8'h06);
    condLineErr = 1'b1;
    @(negedge clk);
    chk("R1 line over txem", iirCode, 8'h06);
    rdPulse();
    condLineErr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 latch kept", iirCode, 8'h02);
    rdPulse();
    @(negedge clk);
    chk("R6 cleared after own read", iirCode, 8'h01);

    // R3 freeze with arrival during access
    iirRdEn = 1'b1;
    @(negedge clk);
    condLineErr = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 frozen during read", iirCode, 8'h01);
    iirRdEn = 1'b0;
    @(negedge clk);
    chk("R3 shown after read", iirCode, 8'h06);
    condLineErr = 1'b0;
    wrIer(8'h02);

    // R9 toggle while empty: immediate
    fifoMode = 1'b1;
    latency(n);
    chk("R9 toggle latency", n, 3);
    chk("R2 FIFO bits", iirCode, 8'hC2);
    rdPulse();
    @(negedge clk);

    // R8 deferred: single byte since last indication
    condTxEmpty = 1'b0; txLevel = 5'd1;
    thrPulse();
    @(negedge clk);
    condTxEmpty = 1'b1; txLevel = 5'd0;
    latency(n);
    chk("R8 deferred latency", n, 7);
    rdPulse();
    @(negedge clk);

    // R8 not deferred after two bytes held
    condTxEmpty = 1'b0; txLevel = 5'd2;
    thrPulse();
    txLevel = 5'd1;
    @(negedge clk);
    condTxEmpty = 1'b1; txLevel = 5'd0;
    latency(n);
    chk("R8 multi-byte latency", n, 2);

    // R10 enable rising while empty
    wrIer(8'h00);
    thrPulse();
    @(negedge clk);
    chk("R5 disabled no intr", intr, 0);
    wrIer(8'h02);
    @(negedge clk);
    chk("R10 enable rise sets", iirCode, 8'hC2);
    chk("R5 intr follows", intr, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule